// File: doc/BRIEF.md
# External Interrupt Edge Detector and Request Router

This block turns sixteen asynchronous external request pins into flagged interrupt events. Every pin is brought into the clock domain through two flip-flops. It can then pass through a per-line glitch filter. The filter accepts a new level only after that level has been sampled unchanged for a programmed number of clocks. The accepted level is compared with its value one clock earlier to find rising and falling edges.

A separate enable bit for each edge type decides whether that edge raises the line's pending flag. If an enabled edge arrives while the flag is already pending, a sticky overrun flag is raised as well. Software clears either flag by writing a one to its bit.

Each pending flag drives an interrupt output when the line's request enable is set. The four lowest lines can instead be steered to a DMA request output by a steering bit. For those four lines, a DMA-done pulse from the DMA engine removes the pending flag. A plain write port and a combinational read port give access to all state.

Top module: `ext_irq_router`

## Requirements
- R1: A pin change on a line with its filter off sets that line's pending flag (register 0) so that it is visible after the 4th rising clock edge following the change: 2 synchronizer stages, 1 accepted-level stage, 1 flag stage.
- R2: A rising accepted edge sets the flag only if the line's bit in the rising-enable register (address 2) is 1. A falling edge sets it only if the line's bit in the falling-enable register (address 3) is 1. A disabled edge leaves the flag at 0.
- R3: With the line's bit in the filter-enable register (address 6) set and a limit L in the filter-limit register (address 7), a synchronized level differing from the accepted level is taken only after it has been sampled on L+1 consecutive edges. A return to the accepted level restarts the count, so a shorter pulse sets no flag.
- R4: An enabled edge on a line whose pending flag is already 1 sets that line's overrun bit (register 1). An edge on a line with the flag at 0 does not set it.
- R5: Writing a 1 to a bit of register 0 or register 1 clears that bit. Bits written with 0 keep their value.
- R6: irq_out[i] is 1 exactly when flag i is 1, request-enable bit i (address 4) is 1 and steering bit i (address 5) is 0. The steering register holds only bits 0 to 3; higher bits read as 0.
- R7: For lines 0 to 3, dma_req[i] is 1 exactly when flag i, request-enable bit i and steering bit i are all 1. A steered line keeps irq_out[i] at 0.
- R8: dma_done[i] high at a clock edge clears pending flag i (lines 0 to 3).
- R9: Clearing a flag by a write leaves the filter counter untouched. With L=5, a level change is still accepted on schedule and sets the flag after the 9th edge.
- R10: Synchronous active-low reset sets every register to 0, so all outputs are 0 and all reads return 0.
- R11: Reads are combinational by address. 0 is pending flags, 1 is overruns, 2 is rising enables, 3 is falling enables, 4 is request enables, 5 is steering, 6 is filter enables, 7 is the filter limit in the low bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pin | input | 16 | Asynchronous external request pins |
| dma_done | input | 4 | Transfer-done pulses for lines 0 to 3 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data, combinational |
| irq_out | output | 16 | Interrupt request per line |
| dma_req | output | 4 | DMA request for lines 0 to 3 |

## Verification
A pin change reaches the flag, and so the outputs, after the 4th clock edge when unfiltered, or the (4+L)th when filtered with limit L. Writes, clears and done pulses act at the very next edge. Outputs and reads are combinational from the registers. The bench samples every result half a period after the edge, so each directed check counts edges from the stimulus and reads one cycle before and at the due edge. A behavioural model advanced on every clock compares the outputs and the addressed read each cycle, which catches a result that is early or late by one cycle.

// File: rtl/irq_route_pkg.sv
// Package: shared register addresses for the external interrupt router.
// Assumes a 3-bit register address space with eight registers.
package irq_route_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_FLAG  = 3'd0,
        REG_OVR   = 3'd1,
        REG_RISE  = 3'd2,
        REG_FALL  = 3'd3,
        REG_REQEN = 3'd4,
        REG_STEER = 3'd5,
        REG_FEN   = 3'd6,
        REG_FLIM  = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/irq_line_cond.sv
// Module: per-line input conditioning.
// Two-flop synchronizer, optional stability filter, and raw edge detection.
// Assumes filt_en and filt_lim are quasi-static register outputs.
module irq_line_cond #(
    parameter int FILT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin,
    input  logic              filt_en,
    input  logic [FILT_W-1:0] filt_lim,
    output logic              lvl_sync,
    output logic              lvl_cur,
    output logic              rise,
    output logic              fall
);
    logic              meta_q;
    logic              sync_q;
    logic              cur_q;
    logic              prev_q;
    logic [FILT_W-1:0] cnt_q;

    // Synchronize the pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
        end
    end

    // Accept a new level directly, or after it stays stable for filt_lim+1 samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= 1'b0;
            prev_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            prev_q <= cur_q;
            if (!filt_en) begin
                cur_q <= sync_q;
                cnt_q <= '0;
            end else if (sync_q == cur_q) begin
                cnt_q <= '0;
            end else if (cnt_q == filt_lim) begin
                cur_q <= sync_q;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Raw edges from the accepted level history.
    always_comb begin
        rise = cur_q & ~prev_q;
        fall = ~cur_q & prev_q;
    end

    assign lvl_sync = sync_q;
    assign lvl_cur  = cur_q;
endmodule

// File: rtl/irq_cfg_regs.sv
// Module: configuration registers (edge enables, request enables, steering, filter).
// Assumes FILT_W <= N_LINES and N_DMA <= N_LINES.
module irq_cfg_regs
    import irq_route_pkg::*;
#(
    parameter int N_LINES = 16,
    parameter int N_DMA   = 4,
    parameter int FILT_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [N_LINES-1:0] wr_data,
    output logic [N_LINES-1:0] rise_en,
    output logic [N_LINES-1:0] fall_en,
    output logic [N_LINES-1:0] req_en,
    output logic [N_DMA-1:0]   steer,
    output logic [N_LINES-1:0] filt_en,
    output logic [FILT_W-1:0]  filt_lim
);
    // Load the addressed configuration register on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en  <= '0;
            fall_en  <= '0;
            req_en   <= '0;
            steer    <= '0;
            filt_en  <= '0;
            filt_lim <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_RISE:  rise_en  <= wr_data;
                REG_FALL:  fall_en  <= wr_data;
                REG_REQEN: req_en   <= wr_data;
                REG_STEER: steer    <= wr_data[N_DMA-1:0];
                REG_FEN:   filt_en  <= wr_data;
                REG_FLIM:  filt_lim <= wr_data[FILT_W-1:0];
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/irq_flag_bank.sv
// Module: pending and overrun flags for all lines.
// A new event wins over a clear in the same cycle, so no event is lost.
module irq_flag_bank #(
    parameter int N_LINES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] event_in,
    input  logic [N_LINES-1:0] clr_flag,
    input  logic [N_LINES-1:0] clr_ovr,
    output logic [N_LINES-1:0] flag,
    output logic [N_LINES-1:0] ovr
);
    // Set on events, clear on request; overrun on event while already pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= '0;
            ovr  <= '0;
        end else begin
            flag <= (flag & ~clr_flag) | event_in;
            ovr  <= (ovr & ~clr_ovr) | (event_in & flag);
        end
    end
endmodule

// File: rtl/ext_irq_router.sv
// Module: top of the external interrupt edge detector and request router.
// Conditions each pin, flags enabled edges, and routes flags to interrupt
// or (for the low N_DMA lines) DMA request outputs. Reads are combinational.
module ext_irq_router
    import irq_route_pkg::*;
#(
    parameter int N_LINES = 16,
    parameter int N_DMA   = 4,
    parameter int FILT_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_pin,
    input  logic [N_DMA-1:0]   dma_done,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [N_LINES-1:0] wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [N_LINES-1:0] rd_data,
    output logic [N_LINES-1:0] irq_out,
    output logic [N_DMA-1:0]   dma_req
);
    logic [N_LINES-1:0] rise_en, fall_en, req_en, filt_en;
    logic [N_DMA-1:0]   steer;
    logic [FILT_W-1:0]  filt_lim;
    logic [N_LINES-1:0] lvl_sync, lvl_cur, rise_raw, fall_raw;
    logic [N_LINES-1:0] event_v, clr_flag, clr_ovr, flag_q, ovr_q;
    logic [N_LINES-1:0] steer_full;

    irq_cfg_regs #(.N_LINES(N_LINES), .N_DMA(N_DMA), .FILT_W(FILT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rise_en(rise_en), .fall_en(fall_en), .req_en(req_en), .steer(steer),
        .filt_en(filt_en), .filt_lim(filt_lim)
    );

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        irq_line_cond #(.FILT_W(FILT_W)) u_cond (
            .clk(clk), .rst_n(rst_n), .pin(irq_pin[i]),
            .filt_en(filt_en[i]), .filt_lim(filt_lim),
            .lvl_sync(lvl_sync[i]), .lvl_cur(lvl_cur[i]),
            .rise(rise_raw[i]), .fall(fall_raw[i])
        );
    end

    // Qualify edges and form the clear masks from writes and done pulses.
    always_comb begin
        event_v  = (rise_raw & rise_en) | (fall_raw & fall_en);
        clr_flag = N_LINES'(dma_done);
        clr_ovr  = '0;
        if (wr_en && wr_addr == REG_FLAG) clr_flag = clr_flag | wr_data;
        if (wr_en && wr_addr == REG_OVR)  clr_ovr  = wr_data;
    end

    irq_flag_bank #(.N_LINES(N_LINES)) u_flags (
        .clk(clk), .rst_n(rst_n), .event_in(event_v),
        .clr_flag(clr_flag), .clr_ovr(clr_ovr), .flag(flag_q), .ovr(ovr_q)
    );

    // Route each pending flag to the interrupt or DMA path.
    always_comb begin
        steer_full = N_LINES'(steer);
        irq_out    = flag_q & req_en & ~steer_full;
        dma_req    = flag_q[N_DMA-1:0] & req_en[N_DMA-1:0] & steer;
    end

    // Combinational register read.
    always_comb begin
        case (rd_addr)
            REG_FLAG:  rd_data = flag_q;
            REG_OVR:   rd_data = ovr_q;
            REG_RISE:  rd_data = rise_en;
            REG_FALL:  rd_data = fall_en;
            REG_REQEN: rd_data = req_en;
            REG_STEER: rd_data = steer_full;
            REG_FEN:   rd_data = filt_en;
            default:   rd_data = N_LINES'(filt_lim);
        endcase
    end
endmodule

// File: rtl/ext_irq_router_chk.sv
// Module: assertion checker bound to ext_irq_router.
// Relates flags to the edges, done pulses and writes that drive them.
module ext_irq_router_chk
    import irq_route_pkg::*;
#(
    parameter int N_LINES = 16,
    parameter int N_DMA   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [N_LINES-1:0] wr_data,
    input logic [N_DMA-1:0]   dma_done,
    input logic [N_LINES-1:0] event_v,
    input logic [N_LINES-1:0] flag_q,
    input logic [N_LINES-1:0] ovr_q,
    input logic [N_LINES-1:0] lvl_sync,
    input logic [N_LINES-1:0] lvl_cur
);
    for (genvar i = 0; i < N_LINES; i++) begin : g_chk
        p_flag_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q[i]) |-> $past(event_v[i]));
        p_ovr_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovr_q[i]) |-> $past(flag_q[i]));
        p_accept_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(lvl_cur[i]) |-> ($past(lvl_sync[i]) == lvl_cur[i]));
        p_w1c_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == REG_FLAG && wr_data[i] && !event_v[i]) |=> !flag_q[i]);
    end
    for (genvar j = 0; j < N_DMA; j++) begin : g_dma_chk
        p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (dma_done[j] && !event_v[j]) |=> !flag_q[j]);
    end
endmodule

bind ext_irq_router ext_irq_router_chk #(.N_LINES(N_LINES), .N_DMA(N_DMA)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dma_done(dma_done), .event_v(event_v), .flag_q(flag_q), .ovr_q(ovr_q),
    .lvl_sync(lvl_sync), .lvl_cur(lvl_cur)
);

// File: tb/ext_irq_router_test.sv
module ext_irq_router_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_pin = '0;
    logic [3:0]  dma_done = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data, irq_out;
    logic [3:0]  dma_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_router uut (
        .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .dma_done(dma_done),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out), .dma_req(dma_req)
    );

    // Behavioural reference model state
    logic [15:0] m_s1, m_s2, m_cur, m_prev, m_flag, m_ovr;
    logic [15:0] m_rise, m_fall, m_en, m_fen, m_ev, m_cf, m_co;
    logic [3:0]  m_sel;
    int          m_lim;
    int          m_cnt [16];

    function automatic logic [15:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_flag;
            3'd1: return m_ovr;
            3'd2: return m_rise;
            3'd3: return m_fall;
            3'd4: return m_en;
            3'd5: return {12'b0, m_sel};
            3'd6: return m_fen;
            default: return 16'(m_lim);
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_cur = '0; m_prev = '0; m_flag = '0; m_ovr = '0;
            m_rise = '0; m_fall = '0; m_en = '0; m_fen = '0; m_sel = '0; m_lim = 0;
            for (int i = 0; i < 16; i++) m_cnt[i] = 0;
        end else begin
            m_ev = (m_cur & ~m_prev & m_rise) | (~m_cur & m_prev & m_fall);
            m_cf = {12'b0, dma_done};
            m_co = '0;
            if (wr_en && wr_addr == 3'd0) m_cf = m_cf | wr_data;
            if (wr_en && wr_addr == 3'd1) m_co = wr_data;
            m_ovr  = (m_ovr & ~m_co) | (m_ev & m_flag);
            m_flag = (m_flag & ~m_cf) | m_ev;
            m_prev = m_cur;
            for (int i = 0; i < 16; i++) begin
                if (!m_fen[i]) begin
                    m_cur[i] = m_s2[i]; m_cnt[i] = 0;
                end else if (m_s2[i] == m_cur[i]) begin
                    m_cnt[i] = 0;
                end else if (m_cnt[i] == m_lim) begin
                    m_cur[i] = m_s2[i]; m_cnt[i] = 0;
                end else begin
                    m_cnt[i] = m_cnt[i] + 1;
                end
            end
            m_s2 = m_s1;
            m_s1 = irq_pin;
            if (wr_en) begin
                case (wr_addr)
                    3'd2: m_rise = wr_data;
                    3'd3: m_fall = wr_data;
                    3'd4: m_en   = wr_data;
                    3'd5: m_sel  = wr_data[3:0];
                    3'd6: m_fen  = wr_data;
                    3'd7: m_lim  = int'(wr_data[7:0]);
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, mid low phase
    always begin
        @(negedge clk);
        #3;
        if (rst_n && !done) begin
            check("R6 irq_out", irq_out, m_flag & m_en & ~{12'b0, m_sel});
            check("R7 dma_req", dma_req, m_flag[3:0] & m_en[3:0] & m_sel);
            check("R11 rd_data", rd_data, m_read(rd_addr));
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        report();
    end

    initial begin
        logic [15:0] v;
        tick(3);
        rst_n = 1'b1;
        tick();
        // R10: reset state
        check("R10 irq_out", irq_out, 16'h0);
        check("R10 dma_req", {12'b0, dma_req}, 16'h0);
        rd(3'd2, v); check("R10 rise_en", v, 16'h0);
        rd(3'd0, v); check("R10 flags", v, 16'h0);

        wr(3'd2, 16'h00FF);
        wr(3'd3, 16'hFF00);
        wr(3'd4, 16'hFFFF);
        rd(3'd3, v); check("R11 fall_en readback", v, 16'hFF00);

        // R1: unfiltered rise on line 0, due after 4th edge
        rd_addr = 3'd0;
        irq_pin[0] = 1'b1;
        tick(3);
        rd(3'd0, v); check("R1 flag before 4th edge", v & 16'h1, 16'h0);
        tick();
        rd(3'd0, v); check("R1 flag after 4th edge", v & 16'h1, 16'h1);
        check("R6 irq_out line0", irq_out & 16'h1, 16'h1);

        // R2: line 8 has only falling enabled
        irq_pin[8] = 1'b1;
        tick(6);
        rd(3'd0, v); check("R2 rise disabled", v & 16'h0100, 16'h0);
        irq_pin[8] = 1'b0;
        tick(6);
        rd(3'd0, v); check("R2 fall enabled", v & 16'h0100, 16'h0100);

        // R4: disabled fall then enabled rise while pending
        irq_pin[0] = 1'b0;
        tick(6);
        rd(3'd1, v); check("R4 no overrun on disabled edge", v & 16'h1, 16'h0);
        irq_pin[0] = 1'b1;
        tick(6);
        rd(3'd1, v); check("R4 overrun set", v & 16'h1, 16'h1);

        // R5: write-one-to-clear
        wr(3'd0, 16'h0000);
        rd(3'd0, v); check("R5 zero write keeps flags", v & 16'h0101, 16'h0101);
        wr(3'd1, 16'h0001);
        rd(3'd1, v); check("R5 overrun cleared", v & 16'h1, 16'h0);
        wr(3'd0, 16'h0101);
        rd(3'd0, v); check("R5 flags cleared", v & 16'h0101, 16'h0);

        // R6: steering bits above 3 read as zero
        wr(3'd5, 16'hFFFF);
        rd(3'd5, v); check("R6 steer width", v, 16'h000F);
        wr(3'd5, 16'h0002);

        // R7 / R8: DMA path on line 1
        irq_pin[1] = 1'b1;
        tick(4);
        check("R7 dma_req line1", {12'b0, dma_req}, 16'h0002);
        check("R7 irq_out line1 blocked", irq_out & 16'h2, 16'h0);
        dma_done[1] = 1'b1;
        tick();
        dma_done[1] = 1'b0;
        rd(3'd0, v); check("R8 done clears flag", v & 16'h2, 16'h0);
        check("R8 dma_req dropped", {12'b0, dma_req}, 16'h0);

        // R3: filtered line 2 with limit 3
        wr(3'd7, 16'd3);
        wr(3'd6, 16'h000C);
        irq_pin[2] = 1'b1;
        tick(2);
        irq_pin[2] = 1'b0;
        tick(10);
        rd(3'd0, v); check("R3 short pulse rejected", v & 16'h4, 16'h0);
        irq_pin[2] = 1'b1;
        tick(12);
        rd(3'd0, v); check("R3 stable level accepted", v & 16'h4, 16'h4);

        // R9: clear during filtering does not disturb the count (L=5)
        wr(3'd7, 16'd5);
        irq_pin[3] = 1'b1;
        for (int k = 1; k <= 9; k++) begin
            if (k == 5) begin
                wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'h0008;
            end else begin
                wr_en = 1'b0; wr_data = '0;
            end
            tick();
            if (k == 8) begin
                rd(3'd0, v); check("R9 not yet accepted", v & 16'h8, 16'h0);
            end
        end
        wr_en = 1'b0;
        rd(3'd0, v); check("R9 accepted on schedule", v & 16'h8, 16'h8);

        // R10: reset again clears everything
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        #1;
        check("R10 irq_out after reset", irq_out, 16'h0);
        rd(3'd4, v); check("R10 req_en after reset", v, 16'h0);

        tick(2);
        done = 1'b1;
        report();
    end
endmodule